// File: doc/BRIEF.md
# Immediate Barrel Shifter with Carry-Out

This block prepares the second operand of a data-processing operation when the shift distance is a constant taken from the instruction word. It takes a 32-bit operand, a 2-bit shift kind and a 5-bit amount code. It produces the shifted word and the carry the shifter hands out. It also produces the condition flags (carry, negative, zero) that the operation leaves behind. An amount code of zero does not always mean "no shift". For the two right shifts it stands for a full 32-place shift. For rotation it selects a one-place rotate through the incoming carry.

Flag handling is under the control of two enables. When the flag-update enable is low, the shifted word is still produced, and all three incoming flags are passed on unchanged. When the flag-update enable is high, the carry takes the shifter's carry-out. If the compact-form enable is also high, the negative and zero flags are taken from the result. Otherwise the negative and zero flags pass through. The datapath is combinational and is followed by one output register stage, chosen by a parameter that is on by default. Every result is therefore seen one clock after its inputs.

Top module: `imm_shifter`

## Requirements
- R1: With the default output stage, every output reflects the inputs presented one clock earlier. While the synchronous active-high reset is asserted, all outputs are cleared to zero.
- R2: Kind 0 (logical left) with amount 0 returns the operand unchanged, and the carry-out equals the incoming carry.
- R3: Kind 0 with amount n in 1..31 returns the operand shifted left by n with zero fill, and the carry-out equals operand bit 32-n.
- R4: Kind 1 (logical right) with amount 0 behaves as a 32-place shift: the result is all zeros, and the carry-out equals operand bit 31.
- R5: Kind 1 with amount n in 1..31 returns the operand shifted right by n with zero fill, and the carry-out equals operand bit n-1.
- R6: Kind 2 (arithmetic right) with amount 0 behaves as a 32-place shift: every result bit and the carry-out equal operand bit 31.
- R7: Kind 2 with amount n in 1..31 returns the operand shifted right by n with copies of bit 31 filling from the top, and the carry-out equals operand bit n-1.
- R8: Kind 3 (rotate right) with amount n in 1..31 returns the operand rotated right by n, and the carry-out equals operand bit n-1.
- R9: Kind 3 with amount 0 rotates through carry: the result is the operand shifted right by one with the incoming carry in bit 31, and the carry-out equals operand bit 0.
- R10: With the flag-update enable low, the result is still produced, and the carry, negative and zero outputs equal the incoming flags.
- R11: With both the flag-update enable and the compact-form enable high, the negative output equals result bit 31, and the zero output is high exactly when all 32 result bits are zero. With the compact-form enable low, the negative and zero outputs equal the incoming flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| operand_i | input | 32 | Word to be shifted |
| kind_i | input | 2 | Shift kind: 0 left, 1 logical right, 2 arithmetic right, 3 rotate |
| amount_i | input | 5 | Immediate shift amount code |
| carry_i | input | 1 | Current carry flag |
| neg_i | input | 1 | Current negative flag |
| zero_i | input | 1 | Current zero flag |
| flag_en_i | input | 1 | Update flags from this shift |
| nz_en_i | input | 1 | Also update negative and zero from the result |
| result_o | output | 32 | Shifted word |
| carry_o | output | 1 | Carry flag after the operation |
| neg_o | output | 1 | Negative flag after the operation |
| zero_o | output | 1 | Zero flag after the operation |

## Verification
The word, the carry and the two result flags all pass through the same single output register. Each of them is therefore due exactly one rising edge after its inputs. The bench applies each input set on a falling edge. It lets one rising edge pass and then compares all four outputs on the next falling edge, before it presents new inputs. This keeps every comparison inside the one cycle in which that result is valid. The reset state is read on a falling edge while reset is held.

// File: rtl/imm_shift_pkg.sv
package imm_shift_pkg;

    typedef enum logic [1:0] {
        SK_LEFT  = 2'd0,
        SK_RIGHT = 2'd1,
        SK_ARITH = 2'd2,
        SK_ROT   = 2'd3
    } shift_kind_e;

    typedef struct packed {
        logic neg;
        logic zero;
        logic carry;
    } cond_flags_t;

    localparam cond_flags_t FLAGS_CLEAR = '{neg: 1'b0, zero: 1'b0, carry: 1'b0};

    function automatic logic word_is_zero(input logic [63:0] w, input int width);
        logic z;
        z = 1'b1;
        for (int i = 0; i < 64; i++) begin
            if (i < width && w[i]) z = 1'b0;
        end
        return z;
    endfunction

endpackage

// File: rtl/imm_shift_core.sv
module imm_shift_core
    import imm_shift_pkg::*;
#(
    parameter int W     = 32,
    parameter int AMT_W = $clog2(W)
) (
    input  logic [W-1:0]     operand,
    input  shift_kind_e      kind,
    input  logic [AMT_W-1:0] amount,
    input  logic             carry_in,
    output logic [W-1:0]     shifted,
    output logic             shift_carry
);

    logic        amt_zero;
    int unsigned sh;
    logic [W-1:0] left_pre, right_pre;

    assign amt_zero = (amount == '0);

    always_comb begin
        sh        = int'(amount);
        left_pre  = amt_zero ? operand : (operand << (sh - 1));
        right_pre = amt_zero ? operand : (operand >> (sh - 1));
        shifted     = operand;
        shift_carry = carry_in;
        unique case (kind)
            SK_LEFT: begin
                if (!amt_zero) begin
                    shifted     = operand << sh;
                    shift_carry = left_pre[W-1];
                end
            end
            SK_RIGHT: begin
                if (amt_zero) begin
                    shifted     = '0;
                    shift_carry = operand[W-1];
                end else begin
                    shifted     = operand >> sh;
                    shift_carry = right_pre[0];
                end
            end
            SK_ARITH: begin
                if (amt_zero) begin
                    shifted     = {W{operand[W-1]}};
                    shift_carry = operand[W-1];
                end else begin
                    shifted     = W'($signed(operand) >>> sh);
                    shift_carry = right_pre[0];
                end
            end
            SK_ROT: begin
                if (amt_zero) begin
                    shifted     = {carry_in, operand[W-1:1]};
                    shift_carry = operand[0];
                end else begin
                    shifted     = (operand >> sh) | (operand << (W - sh));
                    shift_carry = right_pre[0];
                end
            end
            default: ;
        endcase
    end

    always_comb begin
        if (kind == SK_ROT && amt_zero) begin
            assert_rrx_top_R9: assert (shifted[W-1] == carry_in && shift_carry == operand[0]);
        end
    end

endmodule

// File: rtl/imm_shift_flags.sv
module imm_shift_flags
    import imm_shift_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] result,
    input  logic         shift_carry,
    input  cond_flags_t  flags_in,
    input  logic         flag_en,
    input  logic         nz_en,
    output cond_flags_t  flags_out
);

    logic res_zero;

    assign res_zero = word_is_zero(64'(result), W);

    always_comb begin
        flags_out = flags_in;
        if (flag_en) begin
            flags_out.carry = shift_carry;
            if (nz_en) begin
                flags_out.neg  = result[W-1];
                flags_out.zero = res_zero;
            end
        end
    end

    always_comb begin
        if (!flag_en) begin
            assert_pass_flags_R10: assert (flags_out == flags_in);
        end
    end

endmodule

// File: rtl/imm_shift_stage.sv
module imm_shift_stage
    import imm_shift_pkg::*;
#(
    parameter int W       = 32,
    parameter bit OUT_REG = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_word,
    input  cond_flags_t  d_flags,
    output logic [W-1:0] q_word,
    output cond_flags_t  q_flags
);

    generate
        if (OUT_REG) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    q_word  <= '0;
                    q_flags <= FLAGS_CLEAR;
                end else begin
                    q_word  <= d_word;
                    q_flags <= d_flags;
                end
            end
        end else begin : g_wire
            assign q_word  = d_word;
            assign q_flags = d_flags;
        end
    endgenerate

endmodule

// File: rtl/imm_shifter.sv
module imm_shifter
    import imm_shift_pkg::*;
#(
    parameter int W       = 32,
    parameter bit OUT_REG = 1'b1,
    localparam int AMT_W  = $clog2(W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [W-1:0]     operand_i,
    input  logic [1:0]       kind_i,
    input  logic [AMT_W-1:0] amount_i,
    input  logic             carry_i,
    input  logic             neg_i,
    input  logic             zero_i,
    input  logic             flag_en_i,
    input  logic             nz_en_i,
    output logic [W-1:0]     result_o,
    output logic             carry_o,
    output logic             neg_o,
    output logic             zero_o
);

    shift_kind_e  kind;
    logic [W-1:0] shifted;
    logic         shift_carry;
    cond_flags_t  flags_in, flags_next, flags_q;

    assign kind     = shift_kind_e'(kind_i);
    assign flags_in = '{neg: neg_i, zero: zero_i, carry: carry_i};

    imm_shift_core #(.W(W), .AMT_W(AMT_W)) u_core (
        .operand     (operand_i),
        .kind        (kind),
        .amount      (amount_i),
        .carry_in    (carry_i),
        .shifted     (shifted),
        .shift_carry (shift_carry)
    );

    imm_shift_flags #(.W(W)) u_flags (
        .result      (shifted),
        .shift_carry (shift_carry),
        .flags_in    (flags_in),
        .flag_en     (flag_en_i),
        .nz_en       (nz_en_i),
        .flags_out   (flags_next)
    );

    imm_shift_stage #(.W(W), .OUT_REG(OUT_REG)) u_stage (
        .clk     (clk),
        .rst     (rst),
        .d_word  (shifted),
        .d_flags (flags_next),
        .q_word  (result_o),
        .q_flags (flags_q)
    );

    assign carry_o = flags_q.carry;
    assign neg_o   = flags_q.neg;
    assign zero_o  = flags_q.zero;

    generate
        if (OUT_REG) begin : g_chk
            assert_left_zero_R2: assert property (@(posedge clk) disable iff (rst)
                (kind_i == 2'd0 && amount_i == '0)
                |=> (result_o == $past(operand_i) && (!$past(flag_en_i) || carry_o == $past(carry_i))));

            assert_right_zero_R4: assert property (@(posedge clk) disable iff (rst)
                (kind_i == 2'd1 && amount_i == '0) |=> (result_o == '0));

            assert_arith_zero_R6: assert property (@(posedge clk) disable iff (rst)
                (kind_i == 2'd2 && amount_i == '0) |=> (result_o == {W{$past(operand_i[W-1])}}));

            assert_flags_hold_R10: assert property (@(posedge clk) disable iff (rst)
                !flag_en_i |=> (carry_o == $past(carry_i) && neg_o == $past(neg_i) && zero_o == $past(zero_i)));

            assert_nz_from_result_R11: assert property (@(posedge clk) disable iff (rst)
                (flag_en_i && nz_en_i) |=> (neg_o == result_o[W-1] && zero_o == (result_o == '0)));

            assert_reset_clear_R1: assert property (@(posedge clk)
                rst |=> (result_o == '0 && !carry_o && !neg_o && !zero_o));
        end
    endgenerate

endmodule

// File: tb/tb_imm_shifter.sv
`timescale 1ns/1ps
module tb_imm_shifter;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] operand_i;
    logic [1:0]  kind_i;
    logic [4:0]  amount_i;
    logic        carry_i, neg_i, zero_i, flag_en_i, nz_en_i;
    logic [31:0] result_o;
    logic        carry_o, neg_o, zero_o;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    imm_shifter dut (
        .clk(clk), .rst(rst), .operand_i(operand_i), .kind_i(kind_i),
        .amount_i(amount_i), .carry_i(carry_i), .neg_i(neg_i), .zero_i(zero_i),
        .flag_en_i(flag_en_i), .nz_en_i(nz_en_i), .result_o(result_o),
        .carry_o(carry_o), .neg_o(neg_o), .zero_o(zero_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] pick_op(input int idx);
        case (idx)
            0: return 32'h0000_0000;
            1: return 32'h8000_0000;
            2: return 32'hFFFF_FFFF;
            3: return 32'h1234_5678;
            4: return 32'hA5A5_A5C3;
            default: return 32'h0000_0001;
        endcase
    endfunction

    function automatic string req_tag(input int k, input int n);
        case (k)
            0: return (n == 0) ? "R2" : "R3";
            1: return (n == 0) ? "R4" : "R5";
            2: return (n == 0) ? "R6" : "R7";
            default: return (n == 0) ? "R9" : "R8";
        endcase
    endfunction

    initial begin
        logic [31:0] op, er;
        logic ec, en, ez, sc;
        int s;
        rst = 1'b1; operand_i = 32'hDEAD_BEEF; kind_i = 2'd3; amount_i = 5'd7;
        carry_i = 1'b1; neg_i = 1'b1; zero_i = 1'b1; flag_en_i = 1'b1; nz_en_i = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 reset result", result_o, 32'h0);
        chk("R1 reset flags", {29'd0, carry_o, neg_o, zero_o}, 32'h0);
        rst = 1'b0;
        for (int oi = 0; oi < 6; oi++) begin
            for (int k = 0; k < 4; k++) begin
                for (int n = 0; n < 32; n++) begin
                    for (int ci = 0; ci < 2; ci++) begin
                        for (int fm = 0; fm < 3; fm++) begin
                            op = pick_op(oi);
                            operand_i = op; kind_i = 2'(k); amount_i = 5'(n);
                            carry_i = ci[0]; neg_i = ci[0] ^ n[0]; zero_i = ~ci[0];
                            flag_en_i = (fm != 0); nz_en_i = (fm == 2);
                            // reference model, bit by bit
                            er = '0; sc = carry_i;
                            case (k)
                                0: begin
                                    for (int i = 0; i < 32; i++) er[i] = (i >= n) ? op[i-n] : 1'b0;
                                    if (n != 0) sc = op[32-n];
                                end
                                1: begin
                                    s = (n == 0) ? 32 : n;
                                    for (int i = 0; i < 32; i++) er[i] = (i + s < 32) ? op[i+s] : 1'b0;
                                    sc = op[s-1];
                                end
                                2: begin
                                    s = (n == 0) ? 32 : n;
                                    for (int i = 0; i < 32; i++) er[i] = (i + s < 32) ? op[i+s] : op[31];
                                    sc = op[s-1];
                                end
                                default: begin
                                    if (n == 0) begin
                                        for (int i = 0; i < 31; i++) er[i] = op[i+1];
                                        er[31] = carry_i; sc = op[0];
                                    end else begin
                                        for (int i = 0; i < 32; i++) er[i] = op[(i+n)%32];
                                        sc = op[n-1];
                                    end
                                end
                            endcase
                            ec = flag_en_i ? sc : carry_i;
                            en = (flag_en_i && nz_en_i) ? er[31] : neg_i;
                            ez = (flag_en_i && nz_en_i) ? (er == 32'h0) : zero_i;
                            @(posedge clk);
                            @(negedge clk);
                            chk({req_tag(k, n), " result"}, result_o, er);
                            chk(flag_en_i ? {req_tag(k, n), " carry"} : "R10 carry", 32'(carry_o), 32'(ec));
                            chk((fm == 2) ? "R11 neg" : "R10/R11 neg pass", 32'(neg_o), 32'(en));
                            chk((fm == 2) ? "R11 zero" : "R10/R11 zero pass", 32'(zero_o), 32'(ez));
                        end
                    end
                end
            end
        end
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1'b1;
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule